// File: doc/BRIEF.md
# Instruction Cache Mode Controller

This block stands between the instruction fetch path and the cache line storage and bus interface. For every fetch it chooses one of three outcomes: serve the fetch from the cache, start a burst line fill, or issue a single-beat uncached bus read. It also drives the bus cache-inhibit signal for that read. It holds one valid bit per cache line. The tag comparison happens outside and arrives as a single match bit, and the burst fill engine reports back with a done pulse.

Software steers the block through a control register write port with three fields. The enable field turns caching on. The lock field freezes the cache contents: hits are still served, but misses become uncached reads. The flash field invalidates all lines when it is written high and then written low. A per-page inhibit attribute that arrives with each fetch also forces the uncached path. A hard reset clears all lines and disables the cache. A soft reset only aborts the access in progress.

Top module: `icm_ctrl`

## Requirements
- R1: Hard reset (`rst` high at a clock edge) clears every valid bit, enable, lock and the stored flash field, and returns the controller to idle with `req_ready`=1 and `dec_valid`, `bus_single`, `bus_burst` and `bus_ci` all 0.
- R2: A control write with the flash field 0, made while the flash field last written is 1, clears every valid bit at that clock edge. A write of flash 1 on its own leaves every line intact.
- R3: While the effective enable is 0, every fetch is decided as single-beat (`dec_kind`=3), whatever the tag match. It pulses `bus_single` and raises `bus_ci`.
- R4: After hard reset the cache is disabled (`mode_enable`=0), so the first fetch is single-beat even with a tag match.
- R5: When enabled and unlocked, a fetch whose line is valid and whose tag matches is a hit (`dec_kind`=1) with no bus activity. Any other fetch is a fill (`dec_kind`=2): it pulses `bus_burst` with `bus_ci` low, and `fill_done` then marks that line valid.
- R6: When locked, hits are still served as hits. Misses become single-beat reads with `bus_ci` high, and the missed line is not allocated.
- R7: A fetch with `req_page_inhibit`=1 is decided as single-beat with `bus_ci` high, even when the line is valid and the tag matches.
- R8: Soft reset returns the controller to idle and clears the bus outputs. It keeps every valid bit and the enable and lock settings.
- R9: A control write captures enable and lock at its edge. They become effective (`mode_enable`, `mode_lock`) at the next edge at which the controller is idle. A write made during a fill or bus read takes effect only after that access ends.
- R10: `req_ready` is 0 from the acceptance of a fill or single-beat fetch until the edge that sees `fill_done` or `bus_done`. `bus_ci` stays high through a single-beat read and drops at that edge. A hit leaves `req_ready` at 1.
- R11: A fetch accepted at an edge produces a one-cycle `dec_valid` pulse with its `dec_kind` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hard/power-on reset, active high |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| cfg_we | input | 1 | Control register write strobe |
| cfg_flash | input | 1 | Flash-invalidate field of the write |
| cfg_enable | input | 1 | Cache enable field of the write |
| cfg_lock | input | 1 | Cache lock field of the write |
| req_valid | input | 1 | Fetch request |
| req_index | input | IDX_W | Line index of the fetch |
| req_tag_match | input | 1 | External tag compare result for the fetch |
| req_page_inhibit | input | 1 | Page attribute: access is cache-inhibited |
| fill_done | input | 1 | Burst fill finished |
| bus_done | input | 1 | Single-beat read finished |
| req_ready | output | 1 | Controller idle, fetch can be accepted |
| dec_valid | output | 1 | Decision pulse |
| dec_kind | output | 2 | Decision: 1 hit, 2 fill, 3 single-beat |
| bus_single | output | 1 | Start single-beat read (pulse) |
| bus_burst | output | 1 | Start line fill (pulse) |
| bus_ci | output | 1 | Cache-inhibit signal to the bus |
| mode_enable | output | 1 | Effective enable |
| mode_lock | output | 1 | Effective lock |

## Verification
The bench checks that a flash write of 1 alone keeps lines live and that the following write of 0 kills them. A design that invalidated on the first write, or never invalidated, returns the wrong hit or fill kind. Lock is probed with a miss that must not allocate: a later unlocked fetch with a tag match must still fill, so a design that wrote the line while locked would report a hit. A mode write is made during a fill to show that the enable field holds until `fill_done`. Soft and hard reset are compared: a line filled earlier must survive a soft reset and be lost on a hard one.

// File: rtl/icm_pkg.sv
package icm_pkg;
  typedef enum logic [1:0] {
    K_NONE   = 2'd0,
    K_HIT    = 2'd1,
    K_FILL   = 2'd2,
    K_SINGLE = 2'd3
  } kind_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_FILL = 2'd1,
    S_BUS  = 2'd2
  } state_t;
endpackage

// File: rtl/icm_valid_array.sv
module icm_valid_array #(
  parameter int LINES = 64,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid
);
  logic [LINES-1:0] vld;

  // One flop per line so the whole array can be wiped in a single edge.
  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst || clr_all) begin
        vld[i] <= 1'b0;
      end else if (set_en && (set_idx == IDX_W'(i))) begin
        vld[i] <= 1'b1;
      end
    end
  end

  assign rd_valid = vld[rd_idx];

  p_flash_clear_r2: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (vld == '0))
    else $error("flash clear left a line valid");

endmodule

// File: rtl/icm_mode_regs.sv
module icm_mode_regs (
  input  logic clk,
  input  logic rst,
  input  logic cfg_we,
  input  logic cfg_flash,
  input  logic cfg_enable,
  input  logic cfg_lock,
  input  logic busy,
  output logic flash_clear,
  output logic eff_enable,
  output logic eff_lock
);
  logic flash_q;
  logic pend_enable;
  logic pend_lock;

  // Invalidate on the write that drops the flash field after it was set.
  assign flash_clear = cfg_we && !cfg_flash && flash_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flash_q     <= 1'b0;
      pend_enable <= 1'b0;
      pend_lock   <= 1'b0;
      eff_enable  <= 1'b0;
      eff_lock    <= 1'b0;
    end else begin
      if (cfg_we) begin
        flash_q     <= cfg_flash;
        pend_enable <= cfg_enable;
        pend_lock   <= cfg_lock;
      end
      if (!busy) begin
        eff_enable <= pend_enable;
        eff_lock   <= pend_lock;
      end
    end
  end

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(eff_enable) && $stable(eff_lock)))
    else $error("mode changed during an access");

endmodule

// File: rtl/icm_decide.sv
module icm_decide
  import icm_pkg::*;
(
  input  logic  enable,
  input  logic  lock,
  input  logic  page_inhibit,
  input  logic  line_valid,
  input  logic  tag_match,
  output kind_t kind
);
  logic hit;

  assign hit = line_valid && tag_match;

  always_comb begin
    if (!enable || page_inhibit) begin
      kind = K_SINGLE;
    end else if (hit) begin
      kind = K_HIT;
    end else if (lock) begin
      kind = K_SINGLE;
    end else begin
      kind = K_FILL;
    end
  end
endmodule

// File: rtl/icm_ctrl.sv
module icm_ctrl
  import icm_pkg::*;
#(
  parameter int LINES = 64,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             cfg_we,
  input  logic             cfg_flash,
  input  logic             cfg_enable,
  input  logic             cfg_lock,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_index,
  input  logic             req_tag_match,
  input  logic             req_page_inhibit,
  input  logic             fill_done,
  input  logic             bus_done,
  output logic             req_ready,
  output logic             dec_valid,
  output logic [1:0]       dec_kind,
  output logic             bus_single,
  output logic             bus_burst,
  output logic             bus_ci,
  output logic             mode_enable,
  output logic             mode_lock
);
  state_t           state;
  kind_t            kind;
  logic             line_valid;
  logic             flash_clear;
  logic             set_en;
  logic [IDX_W-1:0] fill_idx;
  logic             busy;

  assign busy      = (state != S_IDLE);
  assign req_ready = !busy;
  assign set_en    = (state == S_FILL) && fill_done && !soft_rst;

  icm_mode_regs u_mode (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_flash   (cfg_flash),
    .cfg_enable  (cfg_enable),
    .cfg_lock    (cfg_lock),
    .busy        (busy),
    .flash_clear (flash_clear),
    .eff_enable  (mode_enable),
    .eff_lock    (mode_lock)
  );

  icm_valid_array #(.LINES(LINES)) u_vld (
    .clk      (clk),
    .rst      (rst),
    .clr_all  (flash_clear),
    .set_en   (set_en),
    .set_idx  (fill_idx),
    .rd_idx   (req_index),
    .rd_valid (line_valid)
  );

  icm_decide u_dec (
    .enable       (mode_enable),
    .lock         (mode_lock),
    .page_inhibit (req_page_inhibit),
    .line_valid   (line_valid),
    .tag_match    (req_tag_match),
    .kind         (kind)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      state      <= S_IDLE;
      dec_valid  <= 1'b0;
      dec_kind   <= K_NONE;
      bus_single <= 1'b0;
      bus_burst  <= 1'b0;
      bus_ci     <= 1'b0;
      fill_idx   <= '0;
    end else begin
      dec_valid  <= 1'b0;
      dec_kind   <= K_NONE;
      bus_single <= 1'b0;
      bus_burst  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            dec_valid <= 1'b1;
            dec_kind  <= kind;
            fill_idx  <= req_index;
            if (kind == K_FILL) begin
              state     <= S_FILL;
              bus_burst <= 1'b1;
            end else if (kind == K_SINGLE) begin
              state      <= S_BUS;
              bus_single <= 1'b1;
              bus_ci     <= 1'b1;
            end
          end
        end
        S_FILL: begin
          if (fill_done) state <= S_IDLE;
        end
        S_BUS: begin
          if (bus_done) begin
            state  <= S_IDLE;
            bus_ci <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_single_ci_r3: assert property (@(posedge clk) disable iff (rst)
    bus_single |-> bus_ci)
    else $error("single-beat read without cache-inhibit");

  p_burst_no_ci_r5: assert property (@(posedge clk) disable iff (rst)
    bus_burst |-> !bus_ci)
    else $error("line fill with cache-inhibit");

  p_fill_unlocked_r6: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_kind == K_FILL) |-> ($past(mode_enable) && !$past(mode_lock)))
    else $error("fill decided while locked or disabled");

  p_ready_low_r10: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (state == S_FILL && !fill_done) |=> !req_ready)
    else $error("ready raised during a fill");

endmodule

// File: tb/sim_icm_ctrl.sv
`timescale 1ns/1ps
module sim_icm_ctrl;
  localparam int LINES = 64;
  localparam int IDX_W = $clog2(LINES);

  logic clk = 1'b0;
  logic rst, soft_rst, cfg_we, cfg_flash, cfg_enable, cfg_lock;
  logic req_valid, req_tag_match, req_page_inhibit, fill_done, bus_done;
  logic [IDX_W-1:0] req_index;
  logic req_ready, dec_valid, bus_single, bus_burst, bus_ci, mode_enable, mode_lock;
  logic [1:0] dec_kind;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  icm_ctrl #(.LINES(LINES)) u0 (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .cfg_we(cfg_we),
    .cfg_flash(cfg_flash), .cfg_enable(cfg_enable), .cfg_lock(cfg_lock),
    .req_valid(req_valid), .req_index(req_index), .req_tag_match(req_tag_match),
    .req_page_inhibit(req_page_inhibit), .fill_done(fill_done), .bus_done(bus_done),
    .req_ready(req_ready), .dec_valid(dec_valid), .dec_kind(dec_kind),
    .bus_single(bus_single), .bus_burst(bus_burst), .bus_ci(bus_ci),
    .mode_enable(mode_enable), .mode_lock(mode_lock)
  );

  task automatic chk(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic fl, input logic en, input logic lk);
    @(negedge clk);
    cfg_we = 1'b1; cfg_flash = fl; cfg_enable = en; cfg_lock = lk;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  // Issue one fetch, check the decision and complete any bus transfer.
  task automatic fetch(input int idx, input logic match, input logic inh,
                       input int exp_kind, input string r);
    @(negedge clk);
    req_valid = 1'b1; req_index = IDX_W'(idx);
    req_tag_match = match; req_page_inhibit = inh;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11", "dec_valid", int'(dec_valid), 1);
    chk(r, "dec_kind", int'(dec_kind), exp_kind);
    if (exp_kind == 2) begin
      chk(r, "bus_burst", int'(bus_burst), 1);
      chk(r, "bus_ci on fill", int'(bus_ci), 0);
      chk("R10", "ready during fill", int'(req_ready), 0);
      fill_done = 1'b1;
      @(negedge clk);
      fill_done = 1'b0;
      chk("R10", "ready after fill", int'(req_ready), 1);
    end else if (exp_kind == 3) begin
      chk(r, "bus_single", int'(bus_single), 1);
      chk(r, "bus_ci", int'(bus_ci), 1);
      chk("R10", "ready during read", int'(req_ready), 0);
      @(negedge clk);
      chk("R10", "bus_ci held", int'(bus_ci), 1);
      bus_done = 1'b1;
      @(negedge clk);
      bus_done = 1'b0;
      chk("R10", "bus_ci dropped", int'(bus_ci), 0);
      chk("R10", "ready after read", int'(req_ready), 1);
    end else begin
      chk(r, "no bus on hit", int'(bus_single | bus_burst), 0);
      chk("R10", "ready on hit", int'(req_ready), 1);
    end
  endtask

  task automatic hard_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "req_ready", int'(req_ready), 1);
    chk("R1", "dec_valid", int'(dec_valid), 0);
    chk("R1", "bus_ci", int'(bus_ci), 0);
    chk("R1", "mode_lock", int'(mode_lock), 0);
    chk("R4", "mode_enable", int'(mode_enable), 0);
    fetch(4, 1'b1, 1'b0, 3, "R4");
  endtask

  task automatic t_disabled();
    fetch(3, 1'b1, 1'b0, 3, "R3");
    fetch(3, 1'b0, 1'b0, 3, "R3");
    cfg_write(1'b0, 1'b1, 1'b0);
    chk("R9", "enable applied when idle", int'(mode_enable), 1);
  endtask

  task automatic t_fill_hit();
    fetch(5, 1'b1, 1'b0, 2, "R5");
    fetch(5, 1'b1, 1'b0, 1, "R5");
    fetch(5, 1'b0, 1'b0, 2, "R5");
    fetch(6, 1'b0, 1'b0, 2, "R5");
  endtask

  task automatic t_inhibit();
    fetch(5, 1'b1, 1'b1, 3, "R7");
    fetch(5, 1'b1, 1'b0, 1, "R7");
  endtask

  task automatic t_lock();
    cfg_write(1'b0, 1'b1, 1'b1);
    chk("R6", "mode_lock", int'(mode_lock), 1);
    fetch(5, 1'b1, 1'b0, 1, "R6");
    fetch(9, 1'b0, 1'b0, 3, "R6");
    cfg_write(1'b0, 1'b1, 1'b0);
    fetch(9, 1'b1, 1'b0, 2, "R6");
  endtask

  task automatic t_flash();
    cfg_write(1'b1, 1'b1, 1'b0);
    fetch(5, 1'b1, 1'b0, 1, "R2");
    fetch(9, 1'b1, 1'b0, 1, "R2");
    cfg_write(1'b0, 1'b1, 1'b0);
    fetch(5, 1'b1, 1'b0, 2, "R2");
    fetch(9, 1'b1, 1'b0, 2, "R2");
  endtask

  task automatic t_soft();
    @(negedge clk);
    req_valid = 1'b1; req_index = IDX_W'(12); req_tag_match = 1'b0; req_page_inhibit = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "fill started", int'(bus_burst), 1);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R8", "idle after soft reset", int'(req_ready), 1);
    chk("R8", "enable kept", int'(mode_enable), 1);
    fetch(5, 1'b1, 1'b0, 1, "R8");
    fetch(12, 1'b1, 1'b0, 2, "R8");
  endtask

  task automatic t_midaccess();
    @(negedge clk);
    req_valid = 1'b1; req_index = IDX_W'(7); req_tag_match = 1'b0; req_page_inhibit = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "fill started", int'(dec_kind), 2);
    cfg_we = 1'b1; cfg_flash = 1'b0; cfg_enable = 1'b0; cfg_lock = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    chk("R9", "enable held while busy", int'(mode_enable), 1);
    fill_done = 1'b1;
    @(negedge clk);
    fill_done = 1'b0;
    chk("R9", "enable held at fill end", int'(mode_enable), 1);
    @(negedge clk);
    chk("R9", "enable applied after fill", int'(mode_enable), 0);
    fetch(7, 1'b1, 1'b0, 3, "R9");
  endtask

  task automatic t_hard();
    cfg_write(1'b0, 1'b1, 1'b0);
    fetch(5, 1'b1, 1'b0, 1, "R1");
    hard_reset();
    chk("R1", "enable cleared", int'(mode_enable), 0);
    fetch(5, 1'b1, 1'b0, 3, "R4");
    cfg_write(1'b0, 1'b1, 1'b0);
    fetch(5, 1'b1, 1'b0, 2, "R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; soft_rst = 1'b0; cfg_we = 1'b0; cfg_flash = 1'b0;
    cfg_enable = 1'b0; cfg_lock = 1'b0; req_valid = 1'b0; req_index = '0;
    req_tag_match = 1'b0; req_page_inhibit = 1'b0; fill_done = 1'b0; bus_done = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_fill_hit();
    t_inhibit();
    t_lock();
    t_flash();
    t_soft();
    t_midaccess();
    t_hard();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule